// File: doc/BRIEF.md
# ADC Channel Polling Sequencer

This block keeps one channel of a four-channel, 8-bit converter on a two-wire serial bus under constant watch. It does not drive the bus pins itself. Instead it sends a fixed series of byte-level commands to a serial-bus master over a valid/ready command port, and it collects the byte that comes back. Each poll addresses the converter for writing and sends a control byte that names the channel. It then addresses the converter again for reading after a repeated start, reads one byte with a closing NACK, and issues a stop.

The channel number comes from two switch inputs. The block samples these switches only at a slow, fixed period, which debounces them. The value is then latched at the start of each poll. Every byte received enters a 16-entry history. The mean of this history is presented both as a raw 8-bit code and as a millivolt figure scaled against a 3300 mV reference. Consecutive polls are separated by a programmable idle gap. A one-cycle pulse marks the end of each gap. A target that fails to acknowledge a write ends the poll early and raises a sticky error flag.

Top module: `adc_poll_seq`

## Requirements
- R1: After reset, `avg_value` and `millivolts` are 0, `err_sticky` and `poll_done` are 0. No command is offered until a full gap of GAP_CYCLES cycles has elapsed.
- R2: Each poll offers exactly these commands, in this order: START (code 0), WRITE (code 2) of 0x90, WRITE of the control byte, RESTART (code 1), WRITE of 0x91, READ with NACK (code 3), STOP (code 4). The bytes 0x90 and 0x91 are the 7-bit device address 1001000 followed by the direction bit, 0 for write and 1 for read.
- R3: The control byte is 0x40 with the channel number in bits [1:0]. Switch code 00, 01, 10 and 11 selects channel 0, 1, 2 and 3 respectively.
- R4: The switch code is captured only when a free-running counter completes DEB_CYCLES cycles. The channel used by a poll is the captured code at the moment that poll starts, and it stays fixed for the whole poll.
- R5: Every byte returned by a READ completion (`rd_valid` high with `cmd_ready`) is shifted into a 16-entry window, newest first. The window starts all zero. `avg_value` is the sum of the window shifted right by 4, and it is updated in the cycle after the byte is taken.
- R6: `millivolts` equals (`avg_value` × 3300) >> 8. It is therefore at most 3287.
- R7: When a STOP completes, the block waits exactly GAP_CYCLES cycles. In the following cycle `poll_done` is high for one cycle, and START is offered at the same time.
- R8: If `ack_error` is high when any WRITE completes, the next command is STOP. The read is skipped, so the window is unchanged. `err_sticky` becomes 1 and stays 1 until reset, and the next poll follows after the normal gap.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_code` and `cmd_wdata` hold steady. The block never offers a code above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw | input | 2 | Channel select switches |
| cmd_valid | output | 1 | Command offered to the serial-bus master |
| cmd_ready | input | 1 | Master idle; command accepted when both are high; a rise after acceptance marks completion |
| cmd_code | output | 3 | 0 start, 1 repeated start, 2 write, 3 read with NACK, 4 stop |
| cmd_wdata | output | 8 | Byte to send with a write command |
| rd_valid | input | 1 | Read byte present, in the cycle `cmd_ready` returns after a read |
| rd_data | input | 8 | Byte returned by the read |
| ack_error | input | 1 | Target did not acknowledge; valid in the cycle `cmd_ready` returns after a write |
| poll_done | output | 1 | One-cycle pulse at the end of each gap |
| err_sticky | output | 1 | Set by any missing acknowledge, cleared by reset |
| avg_value | output | 8 | Mean of the last 16 received bytes |
| millivolts | output | 12 | Mean scaled to millivolts |

## Verification
The bench builds the block with GAP_CYCLES = 40 and DEB_CYCLES = 64. These short periods place dozens of polls, several switch captures and a full turnover of the 16-entry window inside a short run. Because the debounce period is not a multiple of the poll length, the switch captures fall at shifting points within and between polls. This exercises the rule that a poll keeps the channel it started with. The missing-acknowledge path is driven on each of the three writes in turn. A long run of full-scale bytes drives the scaled output to its ceiling.

// File: rtl/adc_poll_seq.sv
module adc_poll_seq #(
  parameter int GAP_CYCLES = 262140,
  parameter int DEB_CYCLES = 1048576,
  parameter int WIN_LOG2   = 4,
  parameter int VREF_MV    = 3300,
  parameter int MV_SHIFT   = 8,
  parameter logic [6:0] DEV_ADDR = 7'h48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  sw,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [2:0]  cmd_code,
  output logic [7:0]  cmd_wdata,
  input  logic        rd_valid,
  input  logic [7:0]  rd_data,
  input  logic        ack_error,
  output logic        poll_done,
  output logic        err_sticky,
  output logic [7:0]  avg_value,
  output logic [11:0] millivolts
);
  localparam int WIN    = 1 << WIN_LOG2;
  localparam int SUM_W  = 8 + WIN_LOG2;
  localparam int GAP_W  = $clog2(GAP_CYCLES);
  localparam int DEB_W  = $clog2(DEB_CYCLES);
  localparam int PROD_W = 8 + $clog2(VREF_MV + 1);
  localparam int MV_W   = PROD_W - MV_SHIFT;

  localparam logic [2:0] C_START = 3'd0, C_RESTART = 3'd1, C_WRITE = 3'd2,
                         C_READ = 3'd3, C_STOP = 3'd4;
  localparam logic [2:0] ST_STOP = 3'd6;

  typedef enum logic [1:0] {S_GAP, S_ISSUE, S_WAIT} state_t;

  state_t            state;
  logic [2:0]        step;
  logic [1:0]        sw_r, chan;
  logic [GAP_W-1:0]  gap_cnt;
  logic [DEB_W-1:0]  deb_cnt;
  logic [7:0]        win [WIN];
  logic [SUM_W-1:0]  sum;
  logic [PROD_W-1:0] prod;
  logic              step_is_write;

  always_comb begin
    cmd_wdata = 8'h00;
    case (step)
      3'd0: cmd_code = C_START;
      3'd1: begin cmd_code = C_WRITE; cmd_wdata = {DEV_ADDR, 1'b0}; end
      3'd2: begin cmd_code = C_WRITE; cmd_wdata = {6'b010000, chan}; end
      3'd3: cmd_code = C_RESTART;
      3'd4: begin cmd_code = C_WRITE; cmd_wdata = {DEV_ADDR, 1'b1}; end
      3'd5: cmd_code = C_READ;
      default: cmd_code = C_STOP;
    endcase
  end

  assign cmd_valid     = (state == S_ISSUE);
  assign step_is_write = (cmd_code == C_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deb_cnt <= '0;
      sw_r    <= 2'b00;
    end else if (deb_cnt == DEB_W'(DEB_CYCLES - 1)) begin
      deb_cnt <= '0;
      sw_r    <= sw;
    end else begin
      deb_cnt <= deb_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_GAP;
      step       <= 3'd0;
      gap_cnt    <= '0;
      chan       <= 2'b00;
      poll_done  <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      poll_done <= 1'b0;
      case (state)
        S_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CYCLES - 1)) begin
            state     <= S_ISSUE;
            step      <= 3'd0;
            chan      <= sw_r;
            poll_done <= 1'b1;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_ISSUE: if (cmd_ready) state <= S_WAIT;
        default: begin
          if (cmd_ready) begin
            if (step == ST_STOP) begin
              state   <= S_GAP;
              gap_cnt <= '0;
            end else if (step_is_write && ack_error) begin
              err_sticky <= 1'b1;
              step       <= ST_STOP;
              state      <= S_ISSUE;
            end else begin
              step  <= step + 1'b1;
              state <= S_ISSUE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) win[i] <= 8'h00;
    end else if (state == S_WAIT && cmd_ready && cmd_code == C_READ && rd_valid) begin
      win[0] <= rd_data;
      for (int i = 1; i < WIN; i++) win[i] <= win[i-1];
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < WIN; i++) sum = sum + SUM_W'(win[i]);
  end

  assign avg_value  = sum[SUM_W-1:WIN_LOG2];
  assign prod       = PROD_W'(avg_value) * PROD_W'(VREF_MV);
  assign millivolts = 12'(prod[PROD_W-1:MV_SHIFT]);

  logic unused_mvw;
  assign unused_mvw = (MV_W == 0);
endmodule

module adc_poll_seq_chk #(
  parameter int VREF_MV = 3300
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [2:0]  cmd_code,
  input logic [7:0]  cmd_wdata,
  input logic        poll_done,
  input logic        err_sticky,
  input logic [11:0] millivolts
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_wdata)); // R9
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_code <= 3'd4); // R9
  AST_DONE_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    poll_done |-> cmd_valid && cmd_code == 3'd0); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    poll_done |=> !poll_done); // R7
  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky); // R8
  AST_MV_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    int'(millivolts) < VREF_MV); // R6
endmodule

bind adc_poll_seq adc_poll_seq_chk #(.VREF_MV(VREF_MV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .poll_done(poll_done),
  .err_sticky(err_sticky), .millivolts(millivolts));

// File: tb/adc_poll_seq_test.sv
module adc_poll_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 40;
  localparam int DEB = 64;
  localparam int LAT = 3;

  logic clk = 0, rst_n = 0;
  logic [1:0] sw = 2'b00;
  logic cmd_valid, cmd_ready, rd_valid, ack_error, poll_done, err_sticky;
  logic [2:0] cmd_code;
  logic [7:0] cmd_wdata, rd_data, avg_value;
  logic [11:0] millivolts;

  adc_poll_seq #(.GAP_CYCLES(GAP), .DEB_CYCLES(DEB)) uut (
    .clk(clk), .rst_n(rst_n), .sw(sw), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ack_error(ack_error), .poll_done(poll_done), .err_sticky(err_sticky),
    .avg_value(avg_value), .millivolts(millivolts));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int nack_sel = 0;
  int sample_mode = 0;
  int rd_count = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] sample_byte(input int k);
    if (sample_mode == 1) return 8'hFF;
    if (sample_mode == 2) return 8'h00;
    return 8'((k * 53 + 7) & 255);
  endfunction

  // behavioural serial-bus master
  int busy;
  logic [2:0] m_code;
  int wr_idx;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ready <= 1'b1; rd_valid <= 1'b0; ack_error <= 1'b0; rd_data <= 8'h00;
      busy = 0; wr_idx = 0; m_code = 3'd0;
    end else begin
      rd_valid <= 1'b0; ack_error <= 1'b0;
      if (cmd_valid && cmd_ready) begin
        cmd_ready <= 1'b0; busy = LAT; m_code = cmd_code;
        if (cmd_code == 3'd0) wr_idx = 0;
        if (cmd_code == 3'd2) wr_idx++;
      end else if (busy > 0) begin
        busy--;
        if (busy == 0) begin
          cmd_ready <= 1'b1;
          if (m_code == 3'd3) begin
            rd_valid <= 1'b1; rd_data <= sample_byte(rd_count); rd_count++;
          end
          if (m_code == 3'd2 && wr_idx == nack_sel) ack_error <= 1'b1;
        end
      end
    end
  end

  // cycle reference model
  int phase, gcnt, mdeb, exp_step, out_step;
  logic [1:0] m_sw, m_ch;
  bit outstanding, exp_done, exp_err;
  logic [2:0] out_code;
  logic [7:0] win_q[$];

  function automatic int model_avg();
    int s = 0;
    foreach (win_q[i]) s += win_q[i];
    return s >> 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; gcnt = 0; mdeb = 0; exp_step = 0; out_step = 0;
      m_sw = 2'b00; m_ch = 2'b00; outstanding = 0; exp_done = 0; exp_err = 0;
      out_code = 3'd0; win_q.delete();
    end else begin
      exp_done = 0;
      if (phase == 0) begin
        if (gcnt == GAP - 1) begin
          m_ch = m_sw; phase = 1; exp_step = 0; exp_done = 1;
        end else gcnt++;
      end
      if (cmd_valid && cmd_ready) begin
        logic [2:0] ec; logic [7:0] ed;
        case (exp_step)
          0: begin ec = 3'd0; ed = 8'h00; end
          1: begin ec = 3'd2; ed = 8'h90; end
          2: begin ec = 3'd2; ed = {6'b010000, m_ch}; end
          3: begin ec = 3'd1; ed = 8'h00; end
          4: begin ec = 3'd2; ed = 8'h91; end
          5: begin ec = 3'd3; ed = 8'h00; end
          default: begin ec = 3'd4; ed = 8'h00; end
        endcase
        check(cmd_code == ec, "R2 command order", cmd_code, ec);
        if (exp_step == 2)
          check(cmd_wdata == ed, "R3 R4 control byte channel", cmd_wdata, ed);
        else if (ec == 3'd2)
          check(cmd_wdata == ed, "R2 address byte", cmd_wdata, ed);
        outstanding = 1; out_code = cmd_code; out_step = exp_step; exp_step++;
      end else if (outstanding && cmd_ready) begin
        outstanding = 0;
        if (out_code == 3'd2 && ack_error) begin exp_err = 1; exp_step = 6; end
        if (out_code == 3'd3 && rd_valid) begin
          win_q.push_front(rd_data);
          while (win_q.size() > 16) void'(win_q.pop_back());
        end
        if (out_code == 3'd4) begin phase = 0; gcnt = 0; end
      end
      if (mdeb == DEB - 1) begin m_sw = sw; mdeb = 0; end else mdeb++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int ea, em;
      ea = model_avg();
      em = (ea * 3300) >> 8;
      check(avg_value == 8'(ea), "R5 window average", avg_value, ea);
      check(millivolts == 12'(em), "R6 millivolt scale", millivolts, em);
      check(poll_done == exp_done, "R7 gap and done pulse", poll_done, exp_done);
      check(err_sticky == exp_err, "R8 sticky error", err_sticky, exp_err);
    end
  end

  task automatic run_polls(input int n);
    repeat (n) @(posedge poll_done);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    check(avg_value == 0, "R1 reset average", avg_value, 0);
    check(millivolts == 0, "R1 reset millivolts", millivolts, 0);
    check(err_sticky == 0, "R1 reset error", err_sticky, 0);
    repeat (GAP - 2) @(negedge clk);
    check(cmd_valid == 0, "R1 no command inside first gap", cmd_valid, 0);
    run_polls(20);
    sw = 2'b01; run_polls(5);
    sw = 2'b10; run_polls(3);
    sw = 2'b11; run_polls(3);
    nack_sel = 1; run_polls(1);
    nack_sel = 2; run_polls(1);
    nack_sel = 3; run_polls(1);
    nack_sel = 0; sw = 2'b00; run_polls(3);
    sample_mode = 1; run_polls(20);
    check(avg_value == 8'hFF, "R5 full-scale average", avg_value, 255);
    check(millivolts == 12'd3287, "R6 full-scale millivolts", millivolts, 3287);
    sample_mode = 2; run_polls(4);
    check(err_sticky == 1, "R8 error remains set", err_sticky, 1);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule